// File: doc/BRIEF.md
# Write Strobe and Pulse Generator

This block turns processor write accesses that land in one coarse address region into separate active-low write strobes. Three address bits choose which of eight primary strobes fires. Each strobe can enable an output latch, or it can serve directly as a one-shot trigger such as a clear, an external clock or a count-up pulse. No data bus enters the block, so only the address decides which strobe fires.

The bus phase signal qualifies every strobe. When the phase rises, the block captures the address, the read/write line and the region select in registers. The strobe is then the registered decode gated by the registered phase level. A change on the address or control lines during the phase therefore cannot split a pulse or move it to another strobe. Each write produces exactly one pulse, and that pulse lasts as long as the phase window of the access.

A parameter turns on a second decode level. That level expands one chosen primary strobe into eight secondary strobes, using three more address bits.

Top module: `wstrobe_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, every primary strobe and every secondary strobe is high.
- R2: Take a write access (rw_i = 0) with sel_i = 1, where phi2_i is first sampled high at a rising clock edge. Primary strobe k, with k = addr_i[6:4] (default PRI_LSB = 4), is driven low after that edge. It stays low for exactly as many clock cycles as phi2_i is sampled high. All other primary strobes stay high.
- R3: A read access (rw_i = 1) never drives any strobe low.
- R4: An access with sel_i = 0 at the rising edge of the phase never drives any strobe low.
- R5: Each phase window produces at most one pulse. The pulse returns high in the cycle after phi2_i is first sampled low. Address or rw_i changes during the phase do not change the pulse. An access whose sel_i rises only after phi2_i is already high produces no pulse.
- R6: Address bits outside addr_i[6:4] and, for secondary strobes, outside addr_i[2:0] have no effect on which strobe fires. This includes bit 0.
- R7: With SUB_EN = 1 (default) and a write to primary strobe SUB_SRC (default 7), secondary strobe j, with j = addr_i[2:0] (default SUB_LSB = 0), is low during the same cycles as that primary strobe. In every other case all secondary strobes are high.
- R8: At most one primary strobe and at most one secondary strobe are low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | AW (16) | Address bus |
| rw_i | input | 1 | Read/write line: 1 = read, 0 = write |
| phi2_i | input | 1 | Bus phase signal, high during the data phase |
| sel_i | input | 1 | Coarse region select, active high |
| strobe_n_o | output | 8 | Primary write strobes, active low |
| sub_strobe_n_o | output | 8 | Secondary strobes from the cascaded decode, active low |

## Verification
The bench holds phi2_i high for different lengths so that pulse width errors show up. A design that counted cycles wrongly, or produced a pulse per clock instead of per access, would show a strobe that is too short, too long or repeated.

During the phase, the bench moves the address and flips rw_i to read. A design that decoded the live address would move the pulse to another strobe or drop it. The bench also raises sel_i after the phase has begun, so a design that started on a level rather than on the phase edge would fire a spurious pulse.

Directed writes that differ only in undecoded address bits, including bit 0, would expose decoding of the wrong bit field. Writes to the cascaded strobe would expose a secondary level that ignores its enable or mis-maps its index.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_STB = 1 << SEL_W;

    typedef struct packed {
        logic             armed;
        logic [SEL_W-1:0] pidx;
        logic [SEL_W-1:0] sidx;
        logic             sub_hit;
    } wsg_state_t;
endpackage

// File: rtl/wsg_phase.sv
module wsg_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2_i,
    output logic rise_o,
    output logic level_o
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = phi2_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    assign rise_o  = phi2_i & ~phase_q;
    assign level_o = phase_q;

    // R5
    rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> level_o);
endmodule

// File: rtl/wsg_onehot.sv
module wsg_onehot #(
    parameter int W = 3,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] idx_i,
    input  logic         en_i,
    output logic [N-1:0] out_n_o
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        assign out_n_o[k] = ~(en_i && (idx_i == k[W-1:0]));
    end

    // R8
    always_comb begin
        onehot_out_chk: assert ($countones(~out_n_o) <= 1);
    end
endmodule

// File: rtl/wstrobe_gen.sv
module wstrobe_gen
    import wsg_pkg::*;
#(
    parameter int AW      = 16,
    parameter int PRI_LSB = 4,
    parameter int SUB_LSB = 0,
    parameter bit SUB_EN  = 1'b1,
    parameter int SUB_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      addr_i,
    input  logic               rw_i,
    input  logic               phi2_i,
    input  logic               sel_i,
    output logic [NUM_STB-1:0] strobe_n_o,
    output logic [NUM_STB-1:0] sub_strobe_n_o
);
    localparam logic [SEL_W-1:0] SUB_SRC_L = SUB_SRC[SEL_W-1:0];

    wsg_state_t st_d, st_q;
    logic       rise, level, start, pri_en, sub_en;

    wsg_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phi2_i  (phi2_i),
        .rise_o  (rise),
        .level_o (level)
    );

    assign start = rise & sel_i & ~rw_i;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.armed   = 1'b1;
            st_d.pidx    = addr_i[PRI_LSB +: SEL_W];
            st_d.sidx    = addr_i[SUB_LSB +: SEL_W];
            st_d.sub_hit = SUB_EN && (addr_i[PRI_LSB +: SEL_W] == SUB_SRC_L);
        end else if (!phi2_i) begin
            st_d.armed   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pri_en = st_q.armed & level;
    assign sub_en = pri_en & st_q.sub_hit;

    wsg_onehot #(.W(SEL_W)) u_pri (
        .idx_i   (st_q.pidx),
        .en_i    (pri_en),
        .out_n_o (strobe_n_o)
    );

    if (SUB_EN) begin : g_sub
        wsg_onehot #(.W(SEL_W)) u_sub (
            .idx_i   (st_q.sidx),
            .en_i    (sub_en),
            .out_n_o (sub_strobe_n_o)
        );
    end else begin : g_nosub
        assign sub_strobe_n_o = '1;
    end

    // R2
    low_needs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&strobe_n_o)) |-> $past(phi2_i));

    // R2
    fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&strobe_n_o) |-> $past(~rw_i & sel_i & phi2_i));

    // R5
    steady_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&strobe_n_o) && $past(!(&strobe_n_o))) |-> $stable(strobe_n_o));

    // R7
    sub_inside_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&sub_strobe_n_o)) |-> !strobe_n_o[SUB_SRC]);

    // R8
    pri_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~strobe_n_o));

    // R8
    sub_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sub_strobe_n_o));
endmodule

// File: tb/sim_wstrobe_gen.sv
module sim_wstrobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_i = '0;
    logic        rw_i = 1'b1;
    logic        phi2_i = 1'b0;
    logic        sel_i = 1'b0;
    logic [7:0]  strobe_n_o, sub_strobe_n_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wstrobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rw_i(rw_i),
        .phi2_i(phi2_i), .sel_i(sel_i),
        .strobe_n_o(strobe_n_o), .sub_strobe_n_o(sub_strobe_n_o)
    );

    function automatic logic [7:0] exp_pri(logic [15:0] a, logic rw, logic sel);
        if (sel && !rw) return ~(8'd1 << a[6:4]);
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_sub(logic [15:0] a, logic rw, logic sel);
        if (sel && !rw && a[6:4] == 3'd7) return ~(8'd1 << a[2:0]);
        return 8'hFF;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_onehot();
        nchk++;
        if ($countones(~strobe_n_o) > 1 || $countones(~sub_strobe_n_o) > 1) begin
            nfail++;
            $display("FAIL R8: actual %h/%h expected at most one low",
                     strobe_n_o, sub_strobe_n_o);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one access: phase high for hold cycles, then gap cycles low
    task automatic access(logic [15:0] a, logic rw, logic sel, int hold,
                          int gap, bit disturb, string req);
        logic [7:0] ep = exp_pri(a, rw, sel);
        logic [7:0] es = exp_sub(a, rw, sel);
        addr_i = a; rw_i = rw; sel_i = sel; phi2_i = 1'b1;
        for (int i = 0; i < hold; i++) begin
            cyc();
            check(req, strobe_n_o, ep);
            check("R7", sub_strobe_n_o, es);
            check_onehot();
            if (disturb) begin
                addr_i = 16'($urandom);
                rw_i   = 1'b1;
            end
        end
        phi2_i = 1'b0;
        sel_i  = 1'($urandom);
        rw_i   = 1'($urandom);
        for (int i = 0; i < gap; i++) begin
            cyc();
            check("R5", strobe_n_o, 8'hFF);
            check("R5", sub_strobe_n_o, 8'hFF);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        cyc();
        check("R1", strobe_n_o, 8'hFF);
        check("R1", sub_strobe_n_o, 8'hFF);
        cyc();
        rst_n = 1'b1;
        cyc();
        check("R1", strobe_n_o, 8'hFF);
        check("R1", sub_strobe_n_o, 8'hFF);

        // directed
        access(16'h4451, 1'b0, 1'b1, 3, 1, 1'b0, "R2");
        access(16'h4400, 1'b0, 1'b1, 1, 2, 1'b0, "R2");
        access(16'h4461, 1'b1, 1'b1, 2, 1, 1'b0, "R3");
        access(16'h4431, 1'b0, 1'b0, 2, 1, 1'b0, "R4");
        access(16'h0020, 1'b0, 1'b1, 6, 1, 1'b0, "R5");
        access(16'h0050, 1'b0, 1'b1, 4, 1, 1'b1, "R5");
        access(16'h0035, 1'b0, 1'b1, 2, 1, 1'b0, "R6");
        access(16'hFFB4, 1'b0, 1'b1, 2, 1, 1'b0, "R6");
        access(16'h0073, 1'b0, 1'b1, 2, 1, 1'b0, "R7");
        access(16'hA8F6, 1'b0, 1'b1, 3, 1, 1'b1, "R7");

        // select rises after the phase has begun: no pulse (R5)
        addr_i = 16'h0010; rw_i = 1'b0; sel_i = 1'b0; phi2_i = 1'b1;
        cyc();
        check("R5", strobe_n_o, 8'hFF);
        sel_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc();
            check("R5", strobe_n_o, 8'hFF);
        end
        phi2_i = 1'b0; sel_i = 1'b0;
        cyc();
        check("R5", strobe_n_o, 8'hFF);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a = 16'($urandom);
            logic rw  = ($urandom % 4) == 0;
            logic sel = ($urandom % 5) != 0;
            string tag = !sel ? "R4" : (rw ? "R3" : "R2");
            access(a, rw, sel, 1 + int'($urandom % 5), 1 + int'($urandom % 3),
                   bit'(($urandom % 3) == 0), tag);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule